// File: doc/BRIEF.md
# Channel-Pair Bias Ramp Sequencer

This block governs how one pair of half-bridge power lanes comes out of reset into normal switching and goes back again. A pair-enable input takes the place of the pair's reset pin: while it is low and no ramp-down is in progress, the lanes stay undriven and the block idles in a low-power state. When the enable rises and ramping is allowed, a digital bias level climbs from zero to full scale, one step per prescaler tick. Full scale stands for mid-supply. Normal PWM is released only once that level has been reached. When the enable falls, the level walks back down to zero, and only then are the lanes released to high impedance.

Ramping is allowed only when ramping is requested and the output-mode code selects the four-half-bridge arrangement. In every other mode, and whenever ramping is not requested, the block moves between off and run in a single cycle. A ramp may be reversed part way through. The opposite ramp then starts from the level already reached. The block drives a ramp level for an external bias driver, a lane-enable, a run flag and a one-hot state word. It does not model the analog ramp or the modulation itself.

Top module: `prs_top`

## Requirements
- R1: After `rst`, and whenever the pair is off, `lane_en`=0, `run`=0, `ramp_level`=0 and `state_oh`=4'b0001. The block stays off while `pair_go` is low.
- R2: With ramping allowed, a rising `pair_go` moves the block to ramp-up with `lane_en`=1 on the next edge, starting at level 0. The level rises by one each tick. `run` goes high on the edge after the level reaches full scale (all ones).
- R3: With ramping allowed, a falling `pair_go` in run moves the block to ramp-down, starting at full scale. The level falls by one each tick. `lane_en` drops on the edge after the level reaches 0.
- R4: With ramping not allowed, a rising `pair_go` gives `run`=1 and full-scale level on the next edge. A falling `pair_go` gives `lane_en`=0 and level 0 on the next edge.
- R5: Toggling `pair_go` during a ramp reverses its direction on the next edge. The level is kept, and the new ramp steps on from that value.
- R6: Ramping is allowed only when `ramp_req`=1 and `mode_sel[1:0]`=2'b11; otherwise `ramp_req` has no effect. If ramping stops being allowed during a ramp, the block goes to that ramp's endpoint state on the next edge: run for a ramp-up, off for a ramp-down.
- R7: `state_oh` is always one-hot: bit0 off, bit1 ramp-up, bit2 run, bit3 ramp-down.
- R8: `run`=1 implies full-scale level. While ramping, the level changes by at most one per cycle.
- R9: With `tick_div`=D, a tick occurs every D+1 cycles. The prescaler restarts on every state change, so a full ramp from 0 lasts full-scale×(D+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_go | input | 1 | Pair enable; low stands for the pair's reset being asserted |
| ramp_req | input | 1 | Ramping requested |
| mode_sel | input | 3 | Output-mode code; low two bits 2'b11 select four half-bridges |
| tick_div | input | DIV_W (4) | Prescaler divide value D, giving a step every D+1 cycles |
| ramp_level | output | LVL_W (6) | Digital bias level for the external driver |
| lane_en | output | 1 | Lanes driven (0 means high impedance) |
| run | output | 1 | Normal PWM switching released |
| state_oh | output | 4 | One-hot state word |

## Verification
The assertions assume that `pair_go`, `ramp_req`, `mode_sel` and `tick_div` are synchronous to `clk` and free of X after reset. They also assume that a change in mode eligibility acts on the next edge, just like a change in `pair_go`. The stimulus drives every input on the falling edge only. Random values are kept inside the legal codes, with `tick_div` held between 0 and 3 so that many complete ramps and reversals fit in the run. The directed cases cover ramps at their endpoints, a mid-ramp reversal, ineligible modes, and loss of eligibility during a ramp.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [3:0] {
        ST_OFF  = 4'b0001,
        ST_UP   = 4'b0010,
        ST_RUN  = 4'b0100,
        ST_DOWN = 4'b1000
    } prs_state_e;

    typedef struct packed {
        logic clear;
        logic load_full;
        logic inc;
        logic dec;
    } lvl_cmd_t;

    localparam logic [1:0] QUAD_HALF_CODE = 2'b11;

    function automatic logic ramp_allowed(input logic req, input logic [2:0] mode);
        return req && (mode[1:0] == QUAD_HALF_CODE);
    endfunction

    function automatic logic is_ramping(input prs_state_e s);
        return (s == ST_UP) || (s == ST_DOWN);
    endfunction

endpackage

// File: rtl/prs_prescaler.sv
module prs_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = active && (cnt_q >= div);
endmodule

// File: rtl/prs_level.sv
module prs_level #(
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  prs_pkg::lvl_cmd_t cmd,
    output logic [LVL_W-1:0]  level,
    output logic              at_full,
    output logic              at_zero
);
    localparam logic [LVL_W-1:0] FULL = {LVL_W{1'b1}};

    logic [LVL_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            lvl_q <= '0;
        end else if (cmd.load_full) begin
            lvl_q <= FULL;
        end else if (cmd.inc && lvl_q != FULL) begin
            lvl_q <= lvl_q + 1'b1;
        end else if (cmd.dec && lvl_q != '0) begin
            lvl_q <= lvl_q - 1'b1;
        end
    end

    assign level   = lvl_q;
    assign at_full = (lvl_q == FULL);
    assign at_zero = (lvl_q == '0);
endmodule

// File: rtl/prs_fsm.sv
module prs_fsm (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic                 ramp_ok,
    input  logic                 tick,
    input  logic                 at_full,
    input  logic                 at_zero,
    output prs_pkg::prs_state_e  state,
    output prs_pkg::lvl_cmd_t    cmd,
    output logic                 pre_clr
);
    import prs_pkg::*;

    prs_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        cmd  = '0;
        unique case (st_q)
            ST_OFF: begin
                if (go) begin
                    st_d          = ramp_ok ? ST_UP : ST_RUN;
                    cmd.load_full = !ramp_ok;
                end
            end
            ST_UP: begin
                if (!go) begin
                    st_d      = ramp_ok ? ST_DOWN : ST_OFF;
                    cmd.clear = !ramp_ok;
                end else if (!ramp_ok) begin
                    st_d          = ST_RUN;
                    cmd.load_full = 1'b1;
                end else if (at_full) begin
                    st_d = ST_RUN;
                end else begin
                    cmd.inc = tick;
                end
            end
            ST_RUN: begin
                if (!go) begin
                    st_d      = ramp_ok ? ST_DOWN : ST_OFF;
                    cmd.clear = !ramp_ok;
                end
            end
            ST_DOWN: begin
                if (go) begin
                    st_d          = ramp_ok ? ST_UP : ST_RUN;
                    cmd.load_full = !ramp_ok;
                end else if (!ramp_ok) begin
                    st_d      = ST_OFF;
                    cmd.clear = 1'b1;
                end else if (at_zero) begin
                    st_d = ST_OFF;
                end else begin
                    cmd.dec = tick;
                end
            end
            default: begin
                st_d      = ST_OFF;
                cmd.clear = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_OFF;
        else     st_q <= st_d;
    end

    assign state   = st_q;
    assign pre_clr = (st_d != st_q) || !is_ramping(st_q);
endmodule

// File: rtl/prs_top.sv
module prs_top #(
    parameter int DIV_W = 4,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_go,
    input  logic             ramp_req,
    input  logic [2:0]       mode_sel,
    input  logic [DIV_W-1:0] tick_div,
    output logic [LVL_W-1:0] ramp_level,
    output logic             lane_en,
    output logic             run,
    output logic [3:0]       state_oh
);
    import prs_pkg::*;

    prs_state_e state;
    lvl_cmd_t   cmd;
    logic       ramp_ok, tick, pre_clr, at_full, at_zero;

    assign ramp_ok = ramp_allowed(ramp_req, mode_sel);

    prs_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .go      (pair_go),
        .ramp_ok (ramp_ok),
        .tick    (tick),
        .at_full (at_full),
        .at_zero (at_zero),
        .state   (state),
        .cmd     (cmd),
        .pre_clr (pre_clr)
    );

    prs_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (pre_clr),
        .active (is_ramping(state)),
        .div    (tick_div),
        .tick   (tick)
    );

    prs_level #(.LVL_W(LVL_W)) u_lvl (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .level   (ramp_level),
        .at_full (at_full),
        .at_zero (at_zero)
    );

    assign state_oh = state;
    assign lane_en  = (state != ST_OFF);
    assign run      = (state == ST_RUN);
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             pair_go,
    input logic             ramp_req,
    input logic [2:0]       mode_sel,
    input logic [LVL_W-1:0] ramp_level,
    input logic             lane_en,
    input logic             run,
    input logic [3:0]       state_oh
);
    localparam logic [LVL_W-1:0] FULL = {LVL_W{1'b1}};

    logic elig;
    assign elig = ramp_req && (mode_sel[1:0] == 2'b11);

    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        state_oh[0] |-> (!lane_en && !run && ramp_level == '0));

    p_run_full_r8: assert property (@(posedge clk) disable iff (rst)
        run |-> (ramp_level == FULL && lane_en));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(state_oh[1]) && state_oh[1]) |->
            (ramp_level == $past(ramp_level) || ramp_level == $past(ramp_level) + 1'b1));

    p_ramp_needs_elig_r6: assert property (@(posedge clk) disable iff (rst)
        (state_oh[1] || state_oh[3]) |-> $past(elig));

    p_instant_off_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!pair_go && !elig) && !$past(rst)) |-> state_oh[0]);
endmodule

bind prs_top prs_checker #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pair_go    (pair_go),
    .ramp_req   (ramp_req),
    .mode_sel   (mode_sel),
    .ramp_level (ramp_level),
    .lane_en    (lane_en),
    .run        (run),
    .state_oh   (state_oh)
);

// File: tb/prs_top_test.sv
module prs_top_test;
    localparam int DIV_W = 4;
    localparam int LVL_W = 6;
    localparam int FULL  = (1 << LVL_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pair_go = 1'b0;
    logic ramp_req = 1'b0;
    logic [2:0] mode_sel = 3'b011;
    logic [DIV_W-1:0] tick_div = '0;
    logic [LVL_W-1:0] ramp_level;
    logic lane_en, run;
    logic [3:0] state_oh;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    prs_top #(.DIV_W(DIV_W), .LVL_W(LVL_W)) uut (
        .clk(clk), .rst(rst), .pair_go(pair_go), .ramp_req(ramp_req),
        .mode_sel(mode_sel), .tick_div(tick_div), .ramp_level(ramp_level),
        .lane_en(lane_en), .run(run), .state_oh(state_oh)
    );

    always #4 clk = ~clk;

    function automatic int up_edges(input int d);
        return FULL * (d + 1) + 2;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_run(output int n);
        n = 0;
        do begin
            edges(1);
            n++;
        end while (!run && n < 5000);
    endtask

    task automatic wait_off(output int n);
        n = 0;
        do begin
            edges(1);
            n++;
        end while (lane_en && n < 5000);
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin : main
        int n;
        int prev_lvl;
        void'($urandom(32'd1234));
        edges(3);
        rst = 1'b0;
        edges(5);
        // R1 reset and idle state
        chk("R1 state_oh", state_oh, 4'b0001);
        chk("R1 lane_en", lane_en, 0);
        chk("R1 level", ramp_level, 0);
        chk("R1 run", run, 0);

        // R2/R9 ramp up with D=2
        ramp_req = 1'b1; mode_sel = 3'b011; tick_div = 4'd2;
        pair_go = 1'b1;
        edges(1);
        chk("R2 lane_en at ramp start", lane_en, 1);
        chk("R2 level starts at 0", ramp_level, 0);
        chk("R7 ramp-up code", state_oh, 4'b0010);
        edges(3 * 5);
        chk("R9 level after 5 ticks", ramp_level, 5);
        wait_run(n);
        chk("R2 edges to run", n + 16, up_edges(2));
        chk("R8 level in run", ramp_level, FULL);

        // R3 ramp down with D=2
        pair_go = 1'b0;
        edges(1);
        chk("R3 ramp-down code", state_oh, 4'b1000);
        chk("R3 level starts full", ramp_level, FULL);
        chk("R3 run low", run, 0);
        wait_off(n);
        chk("R3 edges to off", n + 1, up_edges(2));
        chk("R1 level off", ramp_level, 0);

        // R5 reversal with D=0
        tick_div = '0;
        pair_go = 1'b1;
        edges(11);
        chk("R5 level before reversal", ramp_level, 10);
        pair_go = 1'b0;
        edges(1);
        chk("R5 down keeps level", ramp_level, 10);
        chk("R5 state down", state_oh, 4'b1000);
        edges(3);
        chk("R5 stepped down", ramp_level, 7);
        pair_go = 1'b1;
        edges(1);
        chk("R5 up keeps level", ramp_level, 7);
        wait_run(n);
        chk("R5 edges to run", n + 1, FULL - 7 + 2);
        pair_go = 1'b0;
        wait_off(n);

        // R4/R6 ineligible mode ignores ramp_req
        mode_sel = 3'b000; ramp_req = 1'b1; tick_div = 4'd3;
        pair_go = 1'b1;
        edges(1);
        chk("R6 mode 000 run at once", run, 1);
        chk("R4 level full", ramp_level, FULL);
        pair_go = 1'b0;
        edges(1);
        chk("R4 lane off at once", lane_en, 0);
        chk("R4 level zero", ramp_level, 0);
        mode_sel = 3'b111; ramp_req = 1'b0;
        pair_go = 1'b1;
        edges(1);
        chk("R4 no request run at once", run, 1);
        pair_go = 1'b0;
        edges(1);
        chk("R4 no request off", state_oh, 4'b0001);

        // R6 mode 111 is eligible, then loses eligibility mid-ramp
        ramp_req = 1'b1; tick_div = '0;
        pair_go = 1'b1;
        edges(5);
        chk("R6 mode 111 ramps", state_oh, 4'b0010);
        ramp_req = 1'b0;
        edges(1);
        chk("R6 lost eligibility to run", state_oh, 4'b0100);
        chk("R6 level full", ramp_level, FULL);
        ramp_req = 1'b1;
        pair_go = 1'b0;
        edges(4);
        mode_sel = 3'b010;
        edges(1);
        chk("R6 lost eligibility to off", state_oh, 4'b0001);

        // R1 stays off with go low
        mode_sel = 3'b011;
        edges(20);
        chk("R1 remains off", lane_en, 0);

        // random phase: invariants R7/R8/R1
        prev_lvl = ramp_level;
        for (int c = 0; c < 20000; c++) begin
            if ($urandom_range(0, 39) == 0) pair_go = ~pair_go;
            if ($urandom_range(0, 199) == 0) ramp_req = ~ramp_req;
            if ($urandom_range(0, 299) == 0) mode_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 99) == 0) tick_div = DIV_W'($urandom_range(0, 3));
            edges(1);
            chk("R7 one-hot", $countones(state_oh), 1);
            if (run) chk("R8 run level", ramp_level, FULL);
            if (!lane_en) chk("R1 off level", ramp_level, 0);
            if (state_oh[1] || state_oh[3]) begin
                if (ramp_level > prev_lvl) chk("R8 step size", ramp_level - prev_lvl, 1);
                if (ramp_level < prev_lvl) chk("R8 step size", prev_lvl - ramp_level, 1);
            end
            prev_lvl = ramp_level;
        end
        done = 1;
        finish_up();
    end
endmodule